// File: doc/BRIEF.md
# Two-Channel Edge Event Counter with Coherent Capture

This block counts edges on two asynchronous input pins, each with its own 16-bit counter. Each pin passes through a synchronizer. An edge detector then selects rising or falling edges according to a per-channel polarity bit. Software controls the block through a byte-wide register window. The window holds one control register and four count bytes. A write to a count byte loads that byte, which lets software preset or clear either counter. A cascade mode joins the two counters into one 32-bit counter. In that mode only the first pin drives the count, and the second pin is ignored.

Reading a multi-byte count while edges arrive can return a torn value. To avoid this, a capture bit in the control register copies all four count bytes into a holding register. While the bit stays set, reads return the frozen copy, and the live counters keep counting underneath.

A two-state machine runs the capture path:

- `SNAP_LIVE` is the reset state. In this state, reads of the count bytes show the live counters.
- `SNAP_FROZEN` is the capture state. In this state, reads return the holding register.

The machine has two transitions:

- *capture*: `SNAP_LIVE` to `SNAP_FROZEN`, taken on a control write with bit 3 set. This transition loads the holding register.
- *release*: `SNAP_FROZEN` to `SNAP_LIVE`, taken on a control write with bit 3 clear.

Any other control write keeps the current state.

Every register write cycle blocks counting. An edge that would have counted in that cycle is lost.

Top module: `evc_dual_counter`

## Requirements
- R1: After reset, the control register reads 00h and all four count bytes read 00h.
- R2: The control register is at address 0Ch. Bit 0 is the channel-A polarity and bit 1 is the channel-B polarity. Bit 2 enables cascade and bit 3 is the capture bit. Written values read back, and bits 7:4 read 0.
- R3: A counter advances by exactly one per active edge on its pin. Polarity 0 selects rising edges and polarity 1 selects falling edges. The new count is readable from the third rising clock edge after the pin changes.
- R4: Counter A sits at 0Dh (low byte) and 0Eh (high byte). Counter B sits at 0Fh (low) and 10h (high). Every other address reads 00h, and a write to another address changes no register.
- R5: A write to a count byte replaces that byte of the live counter. In any cycle with a register write, no edge is counted and the edge is dropped, not deferred.
- R6: With cascade set, pin A edges advance a 32-bit value with counter B as the upper half, carrying from A into B. Pin B edges change nothing.
- R7: A counter at FFFFh wraps to 0000h on the next edge. In cascade, FFFFFFFFh wraps to 00000000h. The wrap has no other effect.
- R8: A control write that sets bit 3 while it is clear copies all four live count bytes into the holding register. While bit 3 stays set, count-byte reads return that copy, and the live counters keep counting and accept writes.
- R9: Writing bit 3 as 1 while it is already set does not recapture. Clearing bit 3 makes count-byte reads return the live value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in_a | input | 1 | Asynchronous event pin, channel A |
| ev_in_b | input | 1 | Asynchronous event pin, channel B |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |

## Verification
The hardest case to reach is an edge whose count would land in exactly the cycle of a register write. Only in that cycle does the drop rule decide the result. The bench toggles pin A and then waits for a fixed number of falling clock edges before it raises the write strobe. This timing makes the strobe cover the third rising edge after the toggle, which is the edge where the count would land. A behavioural model updated on every clock predicts both this case and the frozen-versus-live read view. The model is compared against the read port at the current address.

// File: rtl/evc_pkg.sv
package evc_pkg;

    // Register window (5-bit byte address space)
    localparam int unsigned CTRL_ADDR = 'h0C;
    localparam int unsigned CNT_BASE  = 'h0D;

    // Control register, bit 0 in the least significant position
    typedef struct packed {
        logic capture;
        logic cascade;
        logic pol_b;
        logic pol_a;
    } ctrl_t;

    typedef enum logic {
        SNAP_LIVE   = 1'b0,
        SNAP_FROZEN = 1'b1
    } snap_state_t;

endpackage

// File: rtl/evc_sync_edge.sv
module evc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic edge_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              level;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    assign level = sync_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // pol = 0: rising, pol = 1: falling
    assign edge_o = pol ? (prev_q & ~level) : (~prev_q & level);

    // An edge pulse lasts one cycle only (R3: one count per edge)
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && $stable(pol)) |=> !edge_o);

endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 edge_a,
    input  logic                 edge_b,
    input  logic                 cascade,
    input  logic                 hold_off,
    input  logic [CNT_W/8-1:0]   ld_a,
    input  logic [CNT_W/8-1:0]   ld_b,
    input  logic [7:0]           ld_data,
    output logic [CNT_W-1:0]     cnt_a,
    output logic [CNT_W-1:0]     cnt_b
);

    localparam int NB = CNT_W / 8;

    logic [CNT_W-1:0]   nxt_a, nxt_b;
    logic [2*CNT_W-1:0] joint_inc;

    assign joint_inc = {cnt_b, cnt_a} + 1'b1;

    always_comb begin
        nxt_a = cnt_a;
        nxt_b = cnt_b;
        if (hold_off) begin
            for (int i = 0; i < NB; i++) begin
                if (ld_a[i]) nxt_a[i*8 +: 8] = ld_data;
                if (ld_b[i]) nxt_b[i*8 +: 8] = ld_data;
            end
        end else if (cascade) begin
            if (edge_a) {nxt_b, nxt_a} = joint_inc;
        end else begin
            if (edge_a) nxt_a = cnt_a + 1'b1;
            if (edge_b) nxt_b = cnt_b + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_a <= '0;
            cnt_b <= '0;
        end else begin
            cnt_a <= nxt_a;
            cnt_b <= nxt_b;
        end
    end

    p_step_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_off && !cascade && edge_a) |=> cnt_a == $past(cnt_a) + 1'b1);

    p_step_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_off && !cascade && edge_b) |=> cnt_b == $past(cnt_b) + 1'b1);

    p_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_off && !(|ld_a) && !(|ld_b)) |=> ($stable(cnt_a) && $stable(cnt_b)));

    p_b_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && !hold_off && !edge_a) |=> ($stable(cnt_a) && $stable(cnt_b)));

    p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && !hold_off && edge_a && (&cnt_a)) |=> cnt_b == $past(cnt_b) + 1'b1);

    p_wrap_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_off && !cascade && edge_a && (&cnt_a)) |=> cnt_a == '0);

endmodule

// File: rtl/evc_snapshot.sv
module evc_snapshot
    import evc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctrl,
    input  logic         cap_bit,
    input  logic [W-1:0] live,
    output logic         frozen,
    output logic [W-1:0] hold_q
);

    snap_state_t state_q, state_d;
    logic        do_capture;

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        do_capture = 1'b0;
        unique case (state_q)
            SNAP_LIVE: begin
                if (wr_ctrl && cap_bit) begin
                    state_d    = SNAP_FROZEN;   // capture
                    do_capture = 1'b1;
                end
            end
            SNAP_FROZEN: begin
                if (wr_ctrl && !cap_bit) state_d = SNAP_LIVE;  // release
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SNAP_LIVE;
        else        state_q <= state_d;
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hold_q <= '0;
        else if (do_capture) hold_q <= live;
    end

    assign frozen = (state_q == SNAP_FROZEN);

    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNAP_LIVE && wr_ctrl && cap_bit)
        |=> (state_q == SNAP_FROZEN && hold_q == $past(live)));

    p_hold_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNAP_FROZEN) |=> $stable(hold_q));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNAP_FROZEN && wr_ctrl && !cap_bit) |=> state_q == SNAP_LIVE);

endmodule

// File: rtl/evc_dual_counter.sv
module evc_dual_counter
    import evc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_in_a,
    input  logic              ev_in_b,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);

    localparam int NB   = CNT_W / 8;
    localparam int TOTB = 2 * NB;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(CNT_BASE);

    ctrl_t               ctrl_q;
    logic                hit_ctrl, hit_cnt;
    logic [ADDR_W-1:0]   off;
    logic [NB-1:0]       ld_a, ld_b;
    logic [2*NB-1:0]     edges;
    logic [1:0]          pins, pols;
    logic [CNT_W-1:0]    cnt_a, cnt_b;
    logic [2*CNT_W-1:0]  live, hold, view;
    logic                frozen;
    logic                unused_hi;

    assign unused_hi = ^reg_wdata[7:4];

    // Address decode
    assign off      = reg_addr - A_BASE;
    assign hit_ctrl = (reg_addr == A_CTRL);
    assign hit_cnt  = (reg_addr >= A_BASE) && (off < ADDR_W'(TOTB));

    generate
        for (genvar i = 0; i < NB; i++) begin : g_ld
            assign ld_a[i] = reg_wr && hit_cnt && (off == ADDR_W'(i));
            assign ld_b[i] = reg_wr && hit_cnt && (off == ADDR_W'(NB + i));
        end
    endgenerate

    // Control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ctrl_q <= '0;
        else if (reg_wr && hit_ctrl) ctrl_q <= reg_wdata[3:0];
    end

    // Input channels
    assign pins = {ev_in_b, ev_in_a};
    assign pols = {ctrl_q.pol_b, ctrl_q.pol_a};

    generate
        for (genvar c = 0; c < 2; c++) begin : g_chan
            evc_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin    (pins[c]),
                .pol    (pols[c]),
                .edge_o (edges[c])
            );
        end
    endgenerate

    evc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_a   (edges[0]),
        .edge_b   (edges[1]),
        .cascade  (ctrl_q.cascade),
        .hold_off (reg_wr),
        .ld_a     (ld_a),
        .ld_b     (ld_b),
        .ld_data  (reg_wdata),
        .cnt_a    (cnt_a),
        .cnt_b    (cnt_b)
    );

    assign live = {cnt_b, cnt_a};

    evc_snapshot #(.W(2*CNT_W)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (reg_wr && hit_ctrl),
        .cap_bit (reg_wdata[3]),
        .live    (live),
        .frozen  (frozen),
        .hold_q  (hold)
    );

    assign view = frozen ? hold : live;

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (hit_ctrl) reg_rdata = {4'b0000, ctrl_q};
        for (int i = 0; i < TOTB; i++) begin
            if (hit_cnt && off == ADDR_W'(i)) reg_rdata = view[i*8 +: 8];
        end
    end

    p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_ctrl) |=> ctrl_q == $past(reg_wdata[3:0]));

    p_stray_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !hit_ctrl && !hit_cnt) |=> ($stable(ctrl_q) && $stable(live)));

    p_state_tracks_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_ctrl) |=> frozen == ctrl_q.capture);

endmodule

// File: tb/test_evc_dual_counter.sv
module test_evc_dual_counter;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_a = 1'b0, ev_b = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = 5'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #(PERIOD/2) clk = ~clk;

    evc_dual_counter i_evc_dual_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_in_a   (ev_a),
        .ev_in_b   (ev_b),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // ---------------- behavioural reference model ----------------
    bit          qa[$];
    bit          qb[$];
    bit          m_pa, m_pb, m_cc, m_rc;
    logic [31:0] m_live, m_hold;

    function automatic logic [7:0] model_read(logic [4:0] a);
        logic [31:0] v;
        v = m_rc ? m_hold : m_live;
        case (a)
            5'h0C:   return {4'b0000, m_rc, m_cc, m_pb, m_pa};
            5'h0D:   return v[7:0];
            5'h0E:   return v[15:8];
            5'h0F:   return v[23:16];
            5'h10:   return v[31:24];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit ea, eb;
        if (!rst_n) begin
            qa = '{0, 0, 0};
            qb = '{0, 0, 0};
            m_pa = 0; m_pb = 0; m_cc = 0; m_rc = 0;
            m_live = 0; m_hold = 0;
        end else begin
            ea = (qa[$-1] != qa[$-2]) && (qa[$-1] == !m_pa);
            eb = (qb[$-1] != qb[$-2]) && (qb[$-1] == !m_pb);
            if (reg_wr) begin
                case (reg_addr)
                    5'h0C: begin
                        if (!m_rc && reg_wdata[3]) m_hold = m_live;
                        {m_rc, m_cc, m_pb, m_pa} = reg_wdata[3:0];
                    end
                    5'h0D: m_live[7:0]   = reg_wdata;
                    5'h0E: m_live[15:8]  = reg_wdata;
                    5'h0F: m_live[23:16] = reg_wdata;
                    5'h10: m_live[31:24] = reg_wdata;
                    default: ;
                endcase
            end else if (m_cc) begin
                if (ea) m_live = m_live + 1;
            end else begin
                if (ea) m_live[15:0]  = m_live[15:0] + 16'd1;
                if (eb) m_live[31:16] = m_live[31:16] + 16'd1;
            end
            qa.push_back(ev_a); void'(qa.pop_front());
            qb.push_back(ev_b); void'(qb.pop_front());
        end
        #(PERIOD/4);
        if (rst_n && !done) check({cur_req, " model"}, reg_rdata, model_read(reg_addr));
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(string tag, logic [4:0] a, logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        @(posedge clk);
        #(PERIOD/4);
        check(tag, reg_rdata, exp);
    endtask

    task automatic pulse_a();
        @(negedge clk); ev_a = 1'b1; idle(4);
        ev_a = 1'b0; idle(4);
    endtask

    task automatic pulse_b();
        @(negedge clk); ev_b = 1'b1; idle(4);
        ev_b = 1'b0; idle(4);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        rd("R1 ctrl", 5'h0C, 8'h00);
        rd("R1 a lo", 5'h0D, 8'h00);
        rd("R1 a hi", 5'h0E, 8'h00);
        rd("R1 b lo", 5'h0F, 8'h00);
        rd("R1 b hi", 5'h10, 8'h00);

        // R2: control layout and readback
        cur_req = "R2";
        wr(5'h0C, 8'hF3);
        rd("R2 ctrl hi bits zero", 5'h0C, 8'h03);
        wr(5'h0C, 8'h04);
        rd("R2 cascade bit", 5'h0C, 8'h04);
        wr(5'h0C, 8'h00);
        rd("R2 cleared", 5'h0C, 8'h00);

        // R3: latency of one rising edge on A
        cur_req = "R3";
        @(negedge clk); reg_addr = 5'h0D; ev_a = 1'b1;
        @(posedge clk); #(PERIOD/4); check("R3 latency edge1", reg_rdata, 8'h00);
        @(posedge clk); #(PERIOD/4); check("R3 latency edge2", reg_rdata, 8'h00);
        @(posedge clk); #(PERIOD/4); check("R3 latency edge3", reg_rdata, 8'h01);
        idle(2); ev_a = 1'b0; idle(4);
        rd("R3 falling ignored", 5'h0D, 8'h01);
        pulse_a(); pulse_a();
        rd("R3 three rising", 5'h0D, 8'h03);
        pulse_b(); pulse_b();
        rd("R3 B two rising", 5'h0F, 8'h02);
        wr(5'h0C, 8'h01);
        pulse_a();
        rd("R3 falling polarity", 5'h0D, 8'h04);
        rd("R3 B untouched", 5'h0F, 8'h02);
        wr(5'h0C, 8'h00);

        // R4 / R5: count loads and address map
        cur_req = "R4";
        wr(5'h0D, 8'hFE); wr(5'h0E, 8'hFF);
        wr(5'h0F, 8'h34); wr(5'h10, 8'h12);
        rd("R5 load a lo", 5'h0D, 8'hFE);
        rd("R5 load a hi", 5'h0E, 8'hFF);
        rd("R4 b lo", 5'h0F, 8'h34);
        rd("R4 b hi", 5'h10, 8'h12);
        wr(5'h05, 8'hAA); wr(5'h11, 8'h5F);
        rd("R4 stray ctrl", 5'h0C, 8'h00);
        rd("R4 stray a lo", 5'h0D, 8'hFE);
        rd("R4 stray b hi", 5'h10, 8'h12);
        rd("R4 unmapped 05", 5'h05, 8'h00);
        rd("R4 unmapped 11", 5'h11, 8'h00);

        // R7: 16-bit wrap
        cur_req = "R7";
        pulse_a(); pulse_a();
        rd("R7 wrap lo", 5'h0D, 8'h00);
        rd("R7 wrap hi", 5'h0E, 8'h00);
        rd("R7 no carry into B", 5'h0F, 8'h34);

        // R5: edge landing on a write cycle is dropped
        cur_req = "R5";
        @(negedge clk); ev_a = 1'b1;
        idle(1);
        wr(5'h05, 8'h00);
        idle(3);
        rd("R5 dropped edge", 5'h0D, 8'h00);
        @(negedge clk); ev_a = 1'b0; idle(4);
        pulse_a();
        rd("R5 next edge counts", 5'h0D, 8'h01);

        // R6: cascade
        cur_req = "R6";
        wr(5'h0D, 8'hFF); wr(5'h0E, 8'hFF);
        wr(5'h0F, 8'h00); wr(5'h10, 8'h00);
        wr(5'h0C, 8'h04);
        pulse_a();
        rd("R6 carry a lo", 5'h0D, 8'h00);
        rd("R6 carry b lo", 5'h0F, 8'h01);
        pulse_b(); pulse_b();
        rd("R6 B ignored", 5'h0F, 8'h01);
        rd("R6 B ignored a", 5'h0D, 8'h00);
        cur_req = "R7";
        wr(5'h0D, 8'hFF); wr(5'h0E, 8'hFF);
        wr(5'h0F, 8'hFF); wr(5'h10, 8'hFF);
        pulse_a();
        rd("R7 32b wrap a lo", 5'h0D, 8'h00);
        rd("R7 32b wrap b hi", 5'h10, 8'h00);
        wr(5'h0C, 8'h00);

        // R8 / R9: capture
        cur_req = "R8";
        wr(5'h0D, 8'h10); wr(5'h0F, 8'h20);
        wr(5'h0C, 8'h08);
        rd("R8 ctrl capture bit", 5'h0C, 8'h08);
        pulse_a(); pulse_a(); pulse_b();
        rd("R8 frozen a", 5'h0D, 8'h10);
        rd("R8 frozen b", 5'h0F, 8'h20);
        cur_req = "R9";
        wr(5'h0C, 8'h08);
        rd("R9 no recapture", 5'h0D, 8'h10);
        wr(5'h0C, 8'h00);
        rd("R9 live a", 5'h0D, 8'h12);
        rd("R9 live b", 5'h0F, 8'h21);
        cur_req = "R8";
        wr(5'h0C, 8'h08);
        wr(5'h0D, 8'h77);
        rd("R8 load while frozen", 5'h0D, 8'h12);
        wr(5'h0C, 8'h00);
        rd("R8 load visible after release", 5'h0D, 8'h77);

        idle(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule